// File: doc/BRIEF.md
# Green-Mode Switching Oscillator with Period Jitter

This block turns a digitized feedback level into the switching pulse train of a peak-current flyback controller. A period counter sets the switching cycle. Each new period comes from the feedback code: heavy load gives the fastest rate. Across a feedback band the period stretches linearly up to a slow floor rate. Light load therefore costs fewer switching events.

A triangular offset is added to every period to spread the switching spectrum. The size of the triangle changes between the normal region and the reduced-rate region. When the feedback code falls very low, the oscillator keeps counting but suppresses the gate, which gives burst operation. A small hysteresis band sets where the gate resumes.

Within each cycle the gate turns on at the cycle start. It turns off at the duty ceiling, or earlier on a current-limit trip. A trip has no effect while the turn-on spike is blanked. After reset the duty ceiling ramps up from zero.

Top module: `gm_osc`

## Requirements
- R1: While rst_n is low, gate and blank_active are 0. The first cycle after reset lasts PER_NORM clocks with the gate held low.
- R2: When fb_code >= FB_HI, the base period is PER_NORM clocks.
- R3: When fb_code <= FB_LO, the base period is PER_GREEN clocks. For FB_LO < fb_code < FB_HI, the base period is PER_NORM + (FB_HI - fb_code) * ((PER_GREEN - PER_NORM) / (FB_HI - FB_LO)).
- R4: Each period equals base - span/2 + t. The offset t moves by exactly one count per cycle as a triangle between 0 and span. The span is JIT_N when fb_code >= FB_HI and JIT_G otherwise.
- R5: Once soft-start is complete, the gate is high from the cycle start for floor(P * DMAX_NUM / 256) clocks, where P is the period of that cycle.
- R6: After reset the duty fraction starts at 0 and rises by 1/256 every SS_DIV clocks until it reaches DMAX_NUM/256. On-times during the ramp are shorter than the final ceiling.
- R7: blank_active is high for the first BLANK clocks of each on-time. A current-limit trip during those clocks has no effect on the gate.
- R8: A trip sampled while the gate is high and blanking has ended drives the gate low from the next clock until the cycle ends. The cycle length does not change, and the next cycle switches normally.
- R9: A cycle that starts at least two clocks after fb_code falls below FB_ZOFF has no gate pulse.
- R10: Burst operation persists while fb_code stays below FB_ZON, and switching resumes in the first cycle that starts after fb_code reaches FB_ZON. When the block is switching, a code between FB_ZOFF and FB_ZON does not stop it.
- R11: cycle_start is high for exactly one clock at the beginning of every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_code | input | FBW | Digitized feedback level |
| ilim_trip | input | 1 | Current-limit comparator trip |
| gate | output | 1 | Power switch drive |
| blank_active | output | 1 | Leading-edge blanking in progress |
| cycle_start | output | 1 | One-clock strobe at the start of each cycle |

## Verification
The two features most likely to fall in the same clock are the end of blanking and a current-limit trip. The bench raises the trip exactly in the first clock after blanking and checks that the gate width is BLANK+1. It also raises the trip only inside the blank window and checks that the on-time is full. A second collision is a trip held through the last clock of a period, which coincides with the reload of the next cycle. In that case the following cycle must still deliver its full on-time. The bench also moves the feedback code across the burst thresholds near cycle boundaries. It checks gate widths of zero or full on both sides of the hysteresis band.

// File: rtl/gmo_pkg.sv
package gmo_pkg;
  localparam int FRAC_W = 8;
  typedef logic [FRAC_W-1:0] frac_t;
  typedef enum logic [1:0] {ZONE_GREEN, ZONE_BAND, ZONE_NORM} load_zone_e;
endpackage

// File: rtl/gmo_period_calc.sv
module gmo_period_calc
  import gmo_pkg::*;
#(
  parameter int FBW       = 8,
  parameter int PW        = 13,
  parameter int PER_NORM  = 1538,
  parameter int PER_GREEN = 4545,
  parameter int FB_HI     = 179,
  parameter int FB_LO     = 147,
  parameter int JIT_N     = 100,
  parameter int JIT_G     = 300
) (
  input  logic [FBW-1:0] fb,
  output logic [PW-1:0]  base,
  output logic [PW-1:0]  span
);
  localparam int SLOPE = (PER_GREEN - PER_NORM) / (FB_HI - FB_LO);
  localparam logic [FBW-1:0] HI_C    = FBW'(FB_HI);
  localparam logic [FBW-1:0] LO_C    = FBW'(FB_LO);
  localparam logic [PW-1:0]  SLOPE_W = PW'(SLOPE);
  localparam logic [PW-1:0]  NORM_W  = PW'(PER_NORM);
  localparam logic [PW-1:0]  GREEN_W = PW'(PER_GREEN);

  load_zone_e     zone;
  logic [FBW-1:0] gap;

  always_comb begin
    if (fb >= HI_C)      zone = ZONE_NORM;
    else if (fb <= LO_C) zone = ZONE_GREEN;
    else                 zone = ZONE_BAND;
    gap = HI_C - fb;
    unique case (zone)
      ZONE_NORM:  base = NORM_W;
      ZONE_GREEN: base = GREEN_W;
      default:    base = NORM_W + PW'(gap) * SLOPE_W;
    endcase
    span = (zone == ZONE_NORM) ? PW'(JIT_N) : PW'(JIT_G);
  end
endmodule

// File: rtl/gmo_jitter.sv
module gmo_jitter #(
  parameter int PW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [PW-1:0] span,
  output logic [PW-1:0] offs
);
  logic rising;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offs   <= '0;
      rising <= 1'b1;
    end else if (step) begin
      if (rising) begin
        if (offs >= span) begin
          rising <= 1'b0;
          offs   <= (offs == '0) ? '0 : offs - 1'b1;
        end else begin
          offs <= offs + 1'b1;
        end
      end else if (offs == '0) begin
        rising <= 1'b1;
        offs   <= (span == '0) ? '0 : PW'(1);
      end else begin
        offs <= offs - 1'b1;
      end
    end
  end
endmodule

// File: rtl/gmo_softstart.sv
module gmo_softstart
  import gmo_pkg::*;
#(
  parameter int SS_DIV   = 3493,
  parameter int DMAX_NUM = 229
) (
  input  logic  clk,
  input  logic  rst_n,
  output frac_t level
);
  localparam int DW = $clog2(SS_DIV) + 1;
  localparam logic [DW-1:0] DIV_END = DW'(SS_DIV - 1);
  localparam frac_t         TOP     = FRAC_W'(DMAX_NUM);

  logic [DW-1:0] div;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div   <= '0;
      level <= '0;
    end else if (level < TOP) begin
      if (div == DIV_END) begin
        div   <= '0;
        level <= level + 1'b1;
      end else begin
        div <= div + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gm_osc.sv
module gm_osc
  import gmo_pkg::*;
#(
  parameter int FBW       = 8,
  parameter int PER_NORM  = 1538,
  parameter int PER_GREEN = 4545,
  parameter int FB_HI     = 179,
  parameter int FB_LO     = 147,
  parameter int FB_ZOFF   = 109,
  parameter int FB_ZON    = 115,
  parameter int JIT_N     = 100,
  parameter int JIT_G     = 300,
  parameter int DMAX_NUM  = 229,
  parameter int SS_DIV    = 3493,
  parameter int BLANK     = 27
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [FBW-1:0] fb_code,
  input  logic           ilim_trip,
  output logic           gate,
  output logic           blank_active,
  output logic           cycle_start
);
  localparam int JMAX = (JIT_N > JIT_G) ? JIT_N : JIT_G;
  localparam int PW   = $clog2(PER_GREEN + JMAX + 1);
  localparam int MW   = PW + FRAC_W;
  localparam logic [FBW-1:0] ZOFF_C  = FBW'(FB_ZOFF);
  localparam logic [FBW-1:0] ZON_C   = FBW'(FB_ZON);
  localparam logic [PW-1:0]  BLANK_C = PW'(BLANK);

  logic [PW-1:0] base, span, offs, per_next, on_next;
  logic [PW-1:0] cnt, per_cur, on_cur;
  logic [MW-1:0] prod;
  frac_t         frac;
  logic          en_cur, trip_r, burst_r, cyc_end;

  gmo_period_calc #(
    .FBW(FBW), .PW(PW), .PER_NORM(PER_NORM), .PER_GREEN(PER_GREEN),
    .FB_HI(FB_HI), .FB_LO(FB_LO), .JIT_N(JIT_N), .JIT_G(JIT_G)
  ) u_calc (
    .fb(fb_code), .base(base), .span(span)
  );

  gmo_jitter #(.PW(PW)) u_jit (
    .clk(clk), .rst_n(rst_n), .step(cyc_end), .span(span), .offs(offs)
  );

  gmo_softstart #(.SS_DIV(SS_DIV), .DMAX_NUM(DMAX_NUM)) u_ss (
    .clk(clk), .rst_n(rst_n), .level(frac)
  );

  always_comb begin
    per_next = base - (span >> 1) + offs;
    prod     = {{FRAC_W{1'b0}}, per_next} * {{PW{1'b0}}, frac};
    on_next  = prod[MW-1:FRAC_W];
    cyc_end  = (cnt == per_cur - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      per_cur <= PW'(PER_NORM);
      on_cur  <= '0;
      en_cur  <= 1'b0;
      trip_r  <= 1'b0;
      burst_r <= 1'b0;
    end else begin
      if (fb_code < ZOFF_C)      burst_r <= 1'b1;
      else if (fb_code >= ZON_C) burst_r <= 1'b0;
      if (cyc_end) begin
        cnt     <= '0;
        per_cur <= per_next;
        on_cur  <= on_next;
        en_cur  <= ~burst_r;
        trip_r  <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
        if (ilim_trip && gate && !blank_active) trip_r <= 1'b1;
      end
    end
  end

  assign gate         = en_cur && (cnt < on_cur) && !trip_r;
  assign blank_active = gate && (cnt < BLANK_C);
  assign cycle_start  = (cnt == '0);
endmodule

// File: rtl/gm_osc_chk.sv
module gm_osc_chk #(
  parameter int FBW       = 8,
  parameter int PW        = 13,
  parameter int PER_NORM  = 1538,
  parameter int PER_GREEN = 4545,
  parameter int FB_ZOFF   = 109,
  parameter int JIT_N     = 100,
  parameter int JIT_G     = 300,
  parameter int DMAX_NUM  = 229
) (
  input logic           clk,
  input logic           rst_n,
  input logic [FBW-1:0] fb_code,
  input logic           ilim_trip,
  input logic           gate,
  input logic           blank_active,
  input logic           cycle_start,
  input logic [PW-1:0]  cnt,
  input logic [PW-1:0]  per_cur,
  input logic [PW-1:0]  on_cur
);
  localparam int JMAX = (JIT_N > JIT_G) ? JIT_N : JIT_G;
  localparam logic [PW-1:0]  P_LOW  = PW'(PER_NORM - JMAX / 2);
  localparam logic [PW-1:0]  P_HIGH = PW'(PER_GREEN + JMAX);
  localparam logic [FBW-1:0] ZOFF_C = FBW'(FB_ZOFF);
  localparam logic [PW+7:0]  DMAX_W = (PW+8)'(DMAX_NUM);

  logic [PW+7:0] lhs, rhs;
  assign lhs = {8'b0, cnt + 1'b1} << 8;
  assign rhs = {8'b0, per_cur} * DMAX_W;

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!gate && !blank_active)); // R1
  AST_PERIOD_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |-> (per_cur >= P_LOW && per_cur <= P_HIGH)); // R4
  AST_DUTY_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (lhs <= rhs)); // R5
  AST_RISE_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> (blank_active && cycle_start)); // R7
  AST_BLANK_IGNORES_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (ilim_trip && blank_active && (cnt + 1'b1 < on_cur)) |=> gate); // R7
  AST_TRIP_ENDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ilim_trip && gate && !blank_active && (cnt != per_cur - 1'b1)) |=> !gate); // R8
  AST_BURST_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && ($past(fb_code, 2) < ZOFF_C)) |-> !gate); // R9
endmodule

bind gm_osc gm_osc_chk #(
  .FBW(FBW), .PW(PW), .PER_NORM(PER_NORM), .PER_GREEN(PER_GREEN),
  .FB_ZOFF(FB_ZOFF), .JIT_N(JIT_N), .JIT_G(JIT_G), .DMAX_NUM(DMAX_NUM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fb_code(fb_code), .ilim_trip(ilim_trip),
  .gate(gate), .blank_active(blank_active), .cycle_start(cycle_start),
  .cnt(cnt), .per_cur(per_cur), .on_cur(on_cur)
);

// File: tb/tb_gm_osc.sv
module tb_gm_osc;
  localparam int PN = 100, PG = 300, HI = 180, LO = 140;
  localparam int ZOFF = 110, ZON = 116, JN = 10, JG = 30;
  localparam int DMAX = 229, SSD = 4, BLK = 27;

  // fb_code, expected base period, expected jitter span
  localparam int NV = 8;
  localparam int VEC [NV][3] = '{
    '{200, 100, 10}, '{180, 100, 10}, '{170, 150, 30}, '{160, 200, 30},
    '{150, 250, 30}, '{141, 295, 30}, '{140, 300, 30}, '{120, 300, 30}};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] fb_code = 8'd200;
  logic       ilim_trip = 1'b0;
  logic       gate, blank_active, cycle_start;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  gm_osc #(
    .FBW(8), .PER_NORM(PN), .PER_GREEN(PG), .FB_HI(HI), .FB_LO(LO),
    .FB_ZOFF(ZOFF), .FB_ZON(ZON), .JIT_N(JN), .JIT_G(JG),
    .DMAX_NUM(DMAX), .SS_DIV(SSD), .BLANK(BLK)
  ) dut (
    .clk(clk), .rst_n(rst_n), .fb_code(fb_code), .ilim_trip(ilim_trip),
    .gate(gate), .blank_active(blank_active), .cycle_start(cycle_start)
  );

  function automatic int full_on(int p);
    return (p * DMAX) / 256;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Measures one cycle from a cycle_start sample; trip is driven on samples [tf, tt).
  task automatic measure(input int tf, input int tt,
                         output int p, output int gw, output int bw, output int cs);
    int i;
    while (!cycle_start) @(negedge clk);
    i = 0; gw = 0; bw = 0; cs = 0;
    do begin
      gw += int'(gate);
      bw += int'(blank_active);
      cs += int'(cycle_start);
      ilim_trip = (i >= tf) && (i < tt);
      i++;
      @(negedge clk);
    end while (!cycle_start && i < 2000);
    ilim_trip = 1'b0;
    p = i;
  endtask

  task automatic skip(int n);
    int p, gw, bw, cs;
    for (int k = 0; k < n; k++) measure(0, 0, p, gw, bw, cs);
  endtask

  task automatic jitter_run(int n, int lo, int hi, string req);
    int p, gw, bw, cs, prev, mn, mx;
    bit steps_ok;
    mn = 1 << 30; mx = 0; prev = -1; steps_ok = 1'b1;
    for (int k = 0; k < n; k++) begin
      measure(0, 0, p, gw, bw, cs);
      if (prev >= 0 && (p - prev != 1) && (prev - p != 1)) steps_ok = 1'b0;
      prev = p;
      if (p < mn) mn = p;
      if (p > mx) mx = p;
    end
    chk(steps_ok, req, int'(steps_ok), 1);
    chk(mn == lo, req, mn, lo);
    chk(mx == hi, req, mx, hi);
  endtask

  initial begin
    int p, gw, bw, cs;
    // R1 reset state
    repeat (5) @(negedge clk);
    chk(gate == 1'b0, "R1 gate in reset", int'(gate), 0);
    chk(blank_active == 1'b0, "R1 blank in reset", int'(blank_active), 0);
    rst_n = 1'b1;
    measure(0, 0, p, gw, bw, cs);
    chk(p == PN, "R1 first period", p, PN);
    chk(gw == 0, "R1 first cycle idle", gw, 0);

    // R6 soft-start ramp
    for (int k = 0; k < 5; k++) begin
      measure(0, 0, p, gw, bw, cs);
      chk(gw > 0 && gw < full_on(p), "R6 ramp on-time", gw, full_on(p));
    end
    skip(6);
    measure(0, 0, p, gw, bw, cs);
    chk(gw == full_on(p), "R6 ramp complete", gw, full_on(p));

    // R2 R3 R5 R7 R11 vector table
    for (int v = 0; v < NV; v++) begin
      fb_code = 8'(VEC[v][0]);
      skip(1);
      measure(0, 0, p, gw, bw, cs);
      chk(p >= VEC[v][1] - VEC[v][2] / 2 && p <= VEC[v][1] + VEC[v][2] / 2,
          (VEC[v][0] >= HI) ? "R2 period" : "R3 period", p, VEC[v][1]);
      chk(gw == full_on(p), "R5 duty ceiling", gw, full_on(p));
      chk(bw == BLK, "R7 blank width", bw, BLK);
      chk(cs == 1, "R11 strobe width", cs, 1);
    end

    // R4 triangular jitter, normal and floor spans
    fb_code = 8'd200;
    skip(35);
    jitter_run(22, PN - JN / 2, PN + JN / 2, "R4 normal jitter");
    fb_code = 8'd130;
    skip(2);
    jitter_run(62, PG - JG / 2, PG + JG / 2, "R4 floor jitter");

    // R7 R8 blanking and current-limit trip
    fb_code = 8'd200;
    skip(35);
    measure(0, 5000, p, gw, bw, cs);
    chk(gw == BLK + 1, "R8 trip held all cycle", gw, BLK + 1);
    chk(bw == BLK, "R7 blank under trip", bw, BLK);
    chk(p >= PN - JN / 2 && p <= PN + JN / 2, "R8 period kept", p, PN);
    measure(0, BLK, p, gw, bw, cs);
    chk(gw == full_on(p), "R7 trip inside blank ignored", gw, full_on(p));
    measure(BLK, BLK + 1, p, gw, bw, cs);
    chk(gw == BLK + 1, "R8 trip at blank end", gw, BLK + 1);
    measure(50, 51, p, gw, bw, cs);
    chk(gw == 51, "R8 mid pulse trip", gw, 51);
    measure(90, 5000, p, gw, bw, cs);
    measure(0, 0, p, gw, bw, cs);
    chk(gw == full_on(p), "R8 next cycle after trip at reload", gw, full_on(p));

    // R9 R10 burst and hysteresis
    fb_code = 8'd105;
    skip(1);
    for (int k = 0; k < 2; k++) begin
      measure(0, 0, p, gw, bw, cs);
      chk(gw == 0, "R9 burst no pulse", gw, 0);
    end
    fb_code = 8'd113;
    for (int k = 0; k < 2; k++) begin
      measure(0, 0, p, gw, bw, cs);
      chk(gw == 0, "R10 stay in burst", gw, 0);
    end
    fb_code = 8'd120;
    skip(1);
    measure(0, 0, p, gw, bw, cs);
    chk(gw == full_on(p), "R10 resume", gw, full_on(p));
    fb_code = 8'd113;
    skip(1);
    measure(0, 0, p, gw, bw, cs);
    chk(gw == full_on(p), "R10 keep switching in band", gw, full_on(p));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule